// File: doc/BRIEF.md
# Prioritised Interrupt Register Bank

This block is the register-facing part of an interrupt controller with `NUM_IRQ` interrupt lines (32 by default). For every line it keeps an enable bit, a pending bit and a `PRIO_W`-bit priority (2 bits by default). Software reaches this state through a small 32-bit register bus. Enable and pending are each seen through two address aliases. Writing a one to the set alias sets the bit, writing a one to the clear alias clears it, and a zero in either alias leaves the bit alone. Priorities are packed four lines to a word, with the priority field at the top of each byte lane.

A rising edge on a hardware interrupt input marks that line pending. Of the lines that are both enabled and pending, the block presents the most urgent one. It drives a request flag and the index of the winning line, which the processor side uses to decide which interrupt to take.

The bus is two streams. A request stream (`req_*`) carries the address, a write flag and write data. A response stream (`rsp_*`) returns exactly one response per accepted request, including writes. A request is accepted on a rising edge when `req_valid` and `req_ready` are both high. Its response is presented on the next cycle and holds steady until `rsp_ready` takes it. The response stage has one slot, so `req_ready` is high when that slot is empty or is being emptied in the same cycle. While a response waits with `rsp_ready` low, no further request is accepted.

Top module: `irqc_top`

## Requirements
- R1: After reset every enable bit, pending bit and priority field is zero, reads of all mapped words return 0, and `irq_req` is low.
- R2: A write to offset 0x100 sets each enable bit whose data bit is 1 and leaves the rest unchanged. A read of 0x100 returns the enable bits, with line i in bit i.
- R3: A write to offset 0x180 clears each enable bit whose data bit is 1 and leaves the rest unchanged. A read of 0x180 also returns the enable bits.
- R4: A write to 0x200 sets pending bits and a write to 0x280 clears pending bits, both only where the data bit is 1. Reads of either offset return the pending bits, with line i in bit i.
- R5: Priority word n sits at offset 0x400 + 4n and covers lines 4n to 4n+3. Line 4n+k uses byte lane k (bits 8k+7:8k), and its priority is bits 8k+7:8k+6. The other bits of each lane read as 0 and ignore writes.
- R6: A rising edge on `irq_in[i]` sets pending bit i one cycle later. A level held high does not set the bit again after software clears it. If a clear write and a rising edge hit the same bit in the same cycle, the bit ends up set.
- R7: `irq_req` is high whenever some line is both enabled and pending. `irq_id` then names the line with the smallest priority value, and a tie goes to the lower line number.
- R8: A line can become pending while it is disabled without raising `irq_req`. It is requested as soon as it is enabled.
- R9: Any offset outside the mapped words, or with address bits 1:0 not zero, reads as 0, and a write to such an offset changes no state.
- R10: Each accepted request gives one response on the following cycle. A write's response carries 0, and a read's response carries the state as it was when the request was accepted. While `rsp_valid` is high and `rsp_ready` is low, `rsp_rdata` stays stable and `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_IRQ | Hardware interrupt lines, edge sensitive |
| req_valid | input | 1 | Request stream valid |
| req_ready | output | 1 | Request stream ready |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response stream valid |
| rsp_ready | input | 1 | Response stream ready |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| irq_req | output | 1 | An enabled, pending line exists |
| irq_id | output | $clog2(NUM_IRQ) | Index of the winning line |

## Verification
A request accepted on edge t has its response on the bus from just after t until the edge at which `rsp_ready` takes it. The state change it makes shows on `irq_req` and `irq_id` right after t, because those outputs are decoded from the state flops without a further register. A rising edge of `irq_in` sampled at edge t is visible in the pending bits, and so in the request outputs, just after t. The bench drives on falling edges and returns from each transfer at the falling edge after acceptance. It therefore samples the request outputs and the scoreboard's responses half a cycle after the edge that produced them, and holds `rsp_ready` low for several cycles to check the stalled response.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int BUS_W = 32;
  localparam int LANES = BUS_W / 8;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_EN_SET,
    SEL_EN_CLR,
    SEL_PD_SET,
    SEL_PD_CLR,
    SEL_PRIO
  } reg_sel_e;

  localparam logic [11:0] OFS_EN_SET = 12'h100;
  localparam logic [11:0] OFS_EN_CLR = 12'h180;
  localparam logic [11:0] OFS_PD_SET = 12'h200;
  localparam logic [11:0] OFS_PD_CLR = 12'h280;
  localparam logic [11:0] OFS_PRIO   = 12'h400;
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int PRIO_WORDS = 8,
  parameter int WORD_W     = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic [WORD_W-1:0] word
);
  localparam logic [ADDR_W-1:0] PRIO_LO = ADDR_W'(OFS_PRIO);
  localparam logic [ADDR_W-1:0] PRIO_HI = ADDR_W'(OFS_PRIO) + ADDR_W'(4 * PRIO_WORDS);

  logic [ADDR_W-1:0] prio_off;

  assign prio_off = addr - PRIO_LO;

  always_comb begin
    sel  = SEL_NONE;
    word = '0;
    if (addr[1:0] == 2'b00) begin
      if (addr == ADDR_W'(OFS_EN_SET))      sel = SEL_EN_SET;
      else if (addr == ADDR_W'(OFS_EN_CLR)) sel = SEL_EN_CLR;
      else if (addr == ADDR_W'(OFS_PD_SET)) sel = SEL_PD_SET;
      else if (addr == ADDR_W'(OFS_PD_CLR)) sel = SEL_PD_CLR;
      else if (addr >= PRIO_LO && addr < PRIO_HI) begin
        sel  = SEL_PRIO;
        word = WORD_W'(prio_off >> 2);
      end
    end
  end
endmodule

// File: rtl/irqc_pending.sv
module irqc_pending #(
  parameter int NUM_IRQ = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic [NUM_IRQ-1:0] set_mask,
  input  logic [NUM_IRQ-1:0] clr_mask,
  output logic [NUM_IRQ-1:0] pend
);
  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    logic line_q;
    logic rise;

    assign rise = irq_in[g] & ~line_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        line_q  <= 1'b0;
        pend[g] <= 1'b0;
      end else begin
        line_q <= irq_in[g];
        // a hardware edge overrides a software clear in the same cycle
        if (rise)             pend[g] <= 1'b1;
        else if (clr_mask[g]) pend[g] <= 1'b0;
        else if (set_mask[g]) pend[g] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/irqc_select.sv
module irqc_select #(
  parameter int NUM_IRQ = 32,
  parameter int PRIO_W  = 2,
  parameter int ID_W    = 5
) (
  input  logic [NUM_IRQ-1:0]             en,
  input  logic [NUM_IRQ-1:0]             pend,
  input  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio,
  output logic                           req,
  output logic [ID_W-1:0]                id
);
  logic [PRIO_W-1:0] best;

  // ascending scan with strict compare keeps the lower index on a tie
  always_comb begin
    req  = 1'b0;
    id   = '0;
    best = '1;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (en[i] && pend[i] && (!req || prio[i] < best)) begin
        req  = 1'b1;
        best = prio[i];
        id   = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int PRIO_W  = 2,
  parameter int ADDR_W  = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_IRQ-1:0]         irq_in,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic                       req_write,
  input  logic [31:0]                req_wdata,
  output logic                       rsp_valid,
  input  logic                       rsp_ready,
  output logic [31:0]                rsp_rdata,
  output logic                       irq_req,
  output logic [$clog2(NUM_IRQ)-1:0] irq_id
);
  localparam int ID_W       = $clog2(NUM_IRQ);
  localparam int PRIO_WORDS = (NUM_IRQ + LANES - 1) / LANES;
  localparam int WORD_W     = (PRIO_WORDS > 1) ? $clog2(PRIO_WORDS) : 1;

  reg_sel_e                   sel;
  logic [WORD_W-1:0]          word;
  logic                       acc;
  logic                       wr_acc;
  logic [NUM_IRQ-1:0]         en_q;
  logic [NUM_IRQ-1:0]         pend_w;
  logic [NUM_IRQ-1:0]         pd_set;
  logic [NUM_IRQ-1:0]         pd_clr;
  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio_q;
  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio_nx;
  logic [NUM_IRQ-1:0]         prio_hit;
  logic [31:0]                rd_mux;

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign wr_acc    = acc && req_write;

  irqc_decode #(
    .ADDR_W    (ADDR_W),
    .PRIO_WORDS(PRIO_WORDS),
    .WORD_W    (WORD_W)
  ) u_dec (
    .addr(req_addr),
    .sel (sel),
    .word(word)
  );

  // enable bits
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (wr_acc && sel == SEL_EN_SET) begin
      en_q <= en_q | req_wdata[NUM_IRQ-1:0];
    end else if (wr_acc && sel == SEL_EN_CLR) begin
      en_q <= en_q & ~req_wdata[NUM_IRQ-1:0];
    end
  end

  // pending bits
  assign pd_set = (wr_acc && sel == SEL_PD_SET) ? req_wdata[NUM_IRQ-1:0] : '0;
  assign pd_clr = (wr_acc && sel == SEL_PD_CLR) ? req_wdata[NUM_IRQ-1:0] : '0;

  irqc_pending #(.NUM_IRQ(NUM_IRQ)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_in  (irq_in),
    .set_mask(pd_set),
    .clr_mask(pd_clr),
    .pend    (pend_w)
  );

  // priority fields: line g lives in lane g%LANES of word g/LANES
  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_prio
    localparam int WIDX = g / LANES;
    localparam int LANE = g % LANES;
    assign prio_hit[g] = wr_acc && sel == SEL_PRIO && word == WORD_W'(WIDX);
    assign prio_nx[g]  = req_wdata[8*LANE+7 -: PRIO_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio_q <= '0;
    end else begin
      for (int i = 0; i < NUM_IRQ; i++) begin
        if (prio_hit[i]) prio_q[i] <= prio_nx[i];
      end
    end
  end

  // read path
  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_EN_SET, SEL_EN_CLR: rd_mux = 32'(en_q);
      SEL_PD_SET, SEL_PD_CLR: rd_mux = 32'(pend_w);
      SEL_PRIO: begin
        for (int k = 0; k < LANES; k++) begin
          if (int'(word) * LANES + k < NUM_IRQ)
            rd_mux[8*k+7 -: PRIO_W] = prio_q[int'(word) * LANES + k];
        end
      end
      default: rd_mux = '0;
    endcase
  end

  // one-slot response stage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (acc) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= req_write ? '0 : rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  irqc_select #(
    .NUM_IRQ(NUM_IRQ),
    .PRIO_W (PRIO_W),
    .ID_W   (ID_W)
  ) u_sel (
    .en  (en_q),
    .pend(pend_w),
    .prio(prio_q),
    .req (irq_req),
    .id  (irq_id)
  );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int PRIO_W  = 2,
  parameter int ADDR_W  = 12
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic [NUM_IRQ-1:0]               irq_in,
  input logic                             req_valid,
  input logic                             req_ready,
  input logic [ADDR_W-1:0]                req_addr,
  input logic                             req_write,
  input logic [31:0]                      req_wdata,
  input logic                             rsp_valid,
  input logic                             rsp_ready,
  input logic [31:0]                      rsp_rdata,
  input logic                             irq_req,
  input logic [$clog2(NUM_IRQ)-1:0]       irq_id,
  input logic [NUM_IRQ-1:0]               en,
  input logic [NUM_IRQ-1:0]               pend,
  input logic [NUM_IRQ-1:0][PRIO_W-1:0]   prio
);
  logic [NUM_IRQ-1:0] in_q;
  logic [NUM_IRQ-1:0] rise;
  logic               better;
  logic               en_set_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) in_q <= '0;
    else        in_q <= irq_in;
  end

  assign rise      = irq_in & ~in_q;
  assign en_set_wr = req_valid && req_ready && req_write && req_addr == ADDR_W'(OFS_EN_SET);

  always_comb begin
    better = 1'b0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (en[i] && pend[i]) begin
        if (prio[i] < prio[irq_id]) better = 1'b1;
        if (prio[i] == prio[irq_id] && i < int'(irq_id)) better = 1'b1;
      end
    end
  end

  p_en_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en_set_wr |=> ((en & $past(req_wdata[NUM_IRQ-1:0])) == $past(req_wdata[NUM_IRQ-1:0])));

  p_edge_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((pend & $past(rise)) == $past(rise)));

  p_winner_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (en[irq_id] && pend[irq_id]));

  p_winner_best_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> !better);

  p_req_raised_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(en & pend)) |-> irq_req);

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

bind irqc_top irqc_checker #(
  .NUM_IRQ(NUM_IRQ),
  .PRIO_W (PRIO_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq_in   (irq_in),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_addr (req_addr),
  .req_write(req_write),
  .req_wdata(req_wdata),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata),
  .irq_req  (irq_req),
  .irq_id   (irq_id),
  .en       (en_q),
  .pend     (pend_w),
  .prio     (prio_q)
);

// File: tb/sim_irqc_top.sv
`timescale 1ns/1ps
module sim_irqc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [11:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic        irq_req;
  logic [4:0]  irq_id;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  irqc_top u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .irq_req(irq_req), .irq_id(irq_id)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // driver: one transfer, expected response pushed on acceptance
  task automatic xfer(input logic wr, input logic [11:0] a, input logic [31:0] d,
                      input logic [31:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    exp_q.push_back(wr ? 32'h0 : exp);
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    xfer(1'b1, a, d, 32'h0, tag);
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    xfer(1'b0, a, 32'h0, exp, tag);
  endtask

  task automatic chk_irq(input logic r, input logic [4:0] id, input string tag);
    check({tag, " irq_req"}, 32'(irq_req), 32'(r));
    if (r) check({tag, " irq_id"}, 32'(irq_id), 32'(id));
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // monitor: pops expected responses as the design delivers them
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R10: actual unexpected response 0x%08h expected none", rsp_rdata);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, rsp_rdata, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected completion");
    summary();
  end

  initial begin
    logic [31:0] held;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk_irq(1'b0, 5'd0, "R1");
    rd(12'h100, 32'h0, "R1 enable");
    rd(12'h200, 32'h0, "R1 pending");
    rd(12'h41C, 32'h0, "R1 prio");

    // R2 / R3: enable aliases
    wr(12'h100, 32'h0000_00F0, "R2 write");
    wr(12'h100, 32'h0000_0001, "R2 write");
    wr(12'h100, 32'h0000_0000, "R2 zero write");
    rd(12'h100, 32'h0000_00F1, "R2 set alias");
    rd(12'h180, 32'h0000_00F1, "R3 read via clear alias");
    wr(12'h180, 32'h0000_0030, "R3 write");
    rd(12'h100, 32'h0000_00C1, "R3 cleared bits");

    // R4: pending aliases
    wr(12'h200, 32'h0000_0084, "R4 write");
    rd(12'h280, 32'h0000_0084, "R4 read via clear alias");
    chk_irq(1'b1, 5'd7, "R7 single");
    wr(12'h280, 32'h0000_0080, "R4 write");
    rd(12'h200, 32'h0000_0004, "R4 cleared");
    chk_irq(1'b0, 5'd0, "R8 disabled pending");
    wr(12'h100, 32'h0000_0004, "R8 write");
    chk_irq(1'b1, 5'd2, "R8 enabled");

    // R5: priority packing, reserved bits
    wr(12'h400, 32'hFFFF_FFFF, "R5 write");
    rd(12'h400, 32'hC0C0_C0C0, "R5 reserved");
    wr(12'h41C, 32'h4000_0080, "R5 write");
    rd(12'h41C, 32'h4000_0080, "R5 lanes");

    // R7: selection by priority then index
    wr(12'h100, 32'h9000_0000, "R7 write");
    wr(12'h200, 32'h9000_0040, "R7 write");
    chk_irq(1'b1, 5'd6, "R7 prio0 wins");
    wr(12'h280, 32'h0000_0040, "R7 write");
    chk_irq(1'b1, 5'd31, "R7 prio1 wins");
    wr(12'h41C, 32'h8000_0080, "R7 write");
    chk_irq(1'b1, 5'd28, "R7 tie lower index");

    // R6 / R8: hardware edges
    wr(12'h280, 32'hFFFF_FFFF, "R6 write");
    @(negedge clk); irq_in[9] = 1'b1;
    @(negedge clk);
    chk_irq(1'b0, 5'd0, "R8 hw pend while disabled");
    rd(12'h200, 32'h0000_0200, "R6 edge");
    wr(12'h280, 32'h0000_0200, "R6 write");
    rd(12'h200, 32'h0000_0000, "R6 level no reset");
    irq_in[9] = 1'b0;
    wr(12'h100, 32'h0000_0200, "R6 write");
    chk_irq(1'b0, 5'd0, "R6 nothing pending");
    irq_in[9] = 1'b1;
    @(negedge clk);
    chk_irq(1'b1, 5'd9, "R6 edge requested");
    wr(12'h280, 32'hFFFF_FFFF, "R6 write");
    irq_in[9] = 1'b0;

    // R6: hardware edge beats same-cycle software clear
    @(negedge clk);
    irq_in[5] = 1'b1;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h280; req_wdata = 32'h0000_0020;
    check("R6 ready for collision", 32'(req_ready), 32'h1);
    exp_q.push_back(32'h0); tag_q.push_back("R6 write");
    @(negedge clk);
    req_valid = 1'b0;
    rd(12'h200, 32'h0000_0020, "R6 hw wins");

    // R9: unmapped space
    wr(12'h300, 32'hFFFF_FFFF, "R9 write");
    wr(12'h102, 32'hFFFF_FFFF, "R9 write");
    wr(12'h420, 32'hFFFF_FFFF, "R9 write");
    rd(12'h300, 32'h0, "R9 read");
    rd(12'h420, 32'h0, "R9 read");
    rd(12'h000, 32'h0, "R9 read");
    rd(12'h100, 32'h9000_02C5, "R9 enable untouched");
    rd(12'h41C, 32'h8000_0080, "R9 prio untouched");

    // R10: back-pressure
    @(negedge clk); rsp_ready = 1'b0;
    rd(12'h280, 32'h0000_0020, "R10 stalled read");
    check("R10 valid", 32'(rsp_valid), 32'h1);
    check("R10 ready low", 32'(req_ready), 32'h0);
    held = rsp_rdata;
    repeat (3) @(negedge clk);
    check("R10 still valid", 32'(rsp_valid), 32'h1);
    check("R10 data stable", rsp_rdata, held);
    rsp_ready = 1'b1;

    repeat (4) @(negedge clk);
    check("R10 all responses", 32'(exp_q.size()), 32'h0);
    summary();
  end
endmodule